// File: doc/BRIEF.md
# UART receive error status register

This block sits between a UART receive path and a register bus. Characters come in from the receiver on a valid/data strobe, each with its own framing, parity and break flags. They are stored together in a small FIFO. Software pops a character by reading the data register. That read returns the character with its error flags in the upper bits. As a side effect, the read copies the popped character's flags into the status register.

The status register always describes the character read last, not the one now at the head of the FIFO. Software must therefore read the data register first and the status register second. The overrun flag is different: it is set on the clock edge at which a character is refused because the FIFO is full, whether or not any read takes place. A write of any value to the status offset clears all four flags. The status offset is read-only for status and write-only for the clear.

Top module: `uart_rx_err_status`

## Requirements
- R1: After reset, a status read returns 0 and a data read returns 0 (the FIFO is empty).
- R2: A data read at offset 0x000 from a non-empty FIFO returns the oldest stored character in bits 7:0, its framing flag in bit 8, its parity flag in bit 9, its break flag in bit 10, the current overrun flag in bit 11 and zero above. Characters come out in arrival order.
- R3: Status bits 0 (framing), 1 (parity) and 2 (break) take the flags of the popped character on the edge that ends a data read from a non-empty FIFO. They change at no other time except on a clear. A status read before the data read therefore returns the previous character's flags.
- R4: When a character arrives while the FIFO holds DEPTH entries and no pop happens in that cycle, status bit 3 (overrun) is set on that edge. The incoming character is discarded and the stored characters are kept unchanged.
- R5: A write of any data value to offset 0x004 clears status bits 3:0 on that edge.
- R6: If an overrun and a clear write happen in the same cycle, the overrun flag ends up set.
- R7: A status read at offset 0x004 returns zero in bits 31:4.
- R8: A data read from an empty FIFO returns 0 and leaves the status register unchanged.
- R9: A character that arrives while the FIFO is full, in the same cycle as a data read, is accepted and does not set overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | Receiver presents a character this cycle |
| rx_data_i | input | DATA_W | Received character |
| rx_frm_err_i | input | 1 | Framing error for the character |
| rx_par_err_i | input | 1 | Parity error for the character |
| rx_brk_i | input | 1 | Break detected with the character |
| bus_req_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset |
| bus_wdata_i | input | BUS_W | Write data (ignored) |
| bus_rdata_o | output | BUS_W | Read data, valid in the cycle of a read |

## Verification
The bench builds the block with a FIFO depth of 4 and keeps the other parameters at their defaults. With this depth, four pushes fill the FIFO. That makes overrun, the push-during-pop case at full, and the overrun-versus-clear collision cheap to set up. It also leaves room to drain the FIFO and show that the dropped character never appears.

// File: rtl/uart_rx_err_pkg.sv
package uart_rx_err_pkg;
  // bit 0 framing, bit 1 parity, bit 2 break
  typedef struct packed {
    logic brk;
    logic par;
    logic frm;
  } rx_flags_t;

  localparam int unsigned FLAGS_W = 3;
  localparam int unsigned STAT_W  = 4;
  localparam int unsigned STAT_OVR = 3;
endpackage

// File: rtl/rx_err_fifo.sv
module rx_err_fifo #(
  parameter int unsigned WIDTH = 11,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  assign do_pop  = pop_i & ~empty_o;
  assign do_push = push_i & (~full_o | do_pop);
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/rx_err_stat.sv
module rx_err_stat
  import uart_rx_err_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  rx_flags_t         flags_i,
  input  logic              ovr_set_i,
  input  logic              clear_i,
  output logic [STAT_W-1:0] stat_o
);
  rx_flags_t flags_q;
  logic      ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      ovr_q   <= 1'b0;
    end else begin
      if (clear_i)        flags_q <= '0;
      else if (capture_i) flags_q <= flags_i;
      // set beats clear so the event is never lost
      if (ovr_set_i)      ovr_q <= 1'b1;
      else if (clear_i)   ovr_q <= 1'b0;
    end
  end

  assign stat_o = {ovr_q, flags_q};
endmodule

// File: rtl/uart_rx_err_status.sv
module uart_rx_err_status
  import uart_rx_err_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned BUS_W    = 32,
  parameter int unsigned OFF_DATA = 'h000,
  parameter int unsigned OFF_STAT = 'h004
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_frm_err_i,
  input  logic              rx_par_err_i,
  input  logic              rx_brk_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o
);
  localparam int unsigned ENT_W = DATA_W + FLAGS_W;
  localparam int unsigned DRD_W = DATA_W + STAT_W;

  logic [ENT_W-1:0]  in_ent, head_ent;
  logic              fifo_empty, fifo_full;
  logic              rd_data, rd_stat, pop, clr, ovr_evt;
  rx_flags_t         in_flags, head_flags;
  logic [STAT_W-1:0] stat_q;
  logic [BUS_W-1:0]  unused_wdata;

  assign unused_wdata = bus_wdata_i;

  assign rd_data = bus_req_i & ~bus_we_i & (bus_addr_i == ADDR_W'(OFF_DATA));
  assign rd_stat = bus_req_i & ~bus_we_i & (bus_addr_i == ADDR_W'(OFF_STAT));
  assign clr     = bus_req_i &  bus_we_i & (bus_addr_i == ADDR_W'(OFF_STAT));
  assign pop     = rd_data & ~fifo_empty;
  assign ovr_evt = rx_valid_i & fifo_full & ~pop;

  assign in_flags = '{brk: rx_brk_i, par: rx_par_err_i, frm: rx_frm_err_i};
  assign in_ent   = {in_flags, rx_data_i};
  assign head_flags = rx_flags_t'(head_ent[ENT_W-1:DATA_W]);

  rx_err_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_valid_i),
    .wdata_i (in_ent),
    .pop_i   (pop),
    .head_o  (head_ent),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  rx_err_stat u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (pop),
    .flags_i   (head_flags),
    .ovr_set_i (ovr_evt),
    .clear_i   (clr),
    .stat_o    (stat_q)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (pop)
      bus_rdata_o = BUS_W'({stat_q[STAT_OVR], head_ent});
    else if (rd_stat)
      bus_rdata_o = BUS_W'(stat_q);
  end

  if (DRD_W > BUS_W) begin : g_width_bad
    initial $error("bus too narrow");
  end
endmodule

// File: rtl/uart_rx_err_status_chk.sv
module uart_rx_err_status_chk #(
  parameter int unsigned BUS_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       stat_q,
  input logic [2:0]       head_flags,
  input logic             pop,
  input logic             clr,
  input logic             ovr_evt,
  input logic             rd_data,
  input logic             rd_stat,
  input logic             fifo_empty,
  input logic             fifo_full,
  input logic [BUS_W-1:0] bus_rdata_o
);
  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pop && !clr) |=> $stable(stat_q[2:0])); // R3
  AST_FLAGS_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && !clr) |=> stat_q[2:0] == $past(head_flags)); // R3
  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_evt |=> stat_q[3]); // R6
  AST_OVR_KEEP_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_evt |=> fifo_full); // R4
  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !ovr_evt) |=> stat_q == 4'b0); // R5
  AST_EMPTY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && fifo_empty) |-> bus_rdata_o == '0); // R8
  AST_STAT_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat |-> bus_rdata_o[BUS_W-1:4] == '0); // R7
endmodule

bind uart_rx_err_status uart_rx_err_status_chk #(.BUS_W(BUS_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stat_q      (stat_q),
  .head_flags  (head_flags),
  .pop         (pop),
  .clr         (clr),
  .ovr_evt     (ovr_evt),
  .rd_data     (rd_data),
  .rd_stat     (rd_stat),
  .fifo_empty  (fifo_empty),
  .fifo_full   (fifo_full),
  .bus_rdata_o (bus_rdata_o)
);

// File: tb/uart_rx_err_status_bench.sv
module uart_rx_err_status_bench;
  localparam int unsigned DEPTH = 4;
  localparam logic [11:0] A_DATA = 12'h000;
  localparam logic [11:0] A_STAT = 12'h004;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_frm = 1'b0, rx_par = 1'b0, rx_brk = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  sb_item_t sb_q[$];

  always #4 clk = ~clk;

  uart_rx_err_status #(.DEPTH(DEPTH)) u_uart_rx_err_status (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .rx_valid_i   (rx_valid),
    .rx_data_i    (rx_data),
    .rx_frm_err_i (rx_frm),
    .rx_par_err_i (rx_par),
    .rx_brk_i     (rx_brk),
    .bus_req_i    (bus_req),
    .bus_we_i     (bus_we),
    .bus_addr_i   (bus_addr),
    .bus_wdata_i  (bus_wdata),
    .bus_rdata_o  (bus_rdata)
  );

  // monitor: compares every bus read against the scoreboard head
  always @(negedge clk) begin
    if (rst_n && bus_req && !bus_we) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: unexpected read, actual %h expected none", bus_rdata);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        if (bus_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  // one cycle of stimulus; a read pushes its expected value
  task automatic step(input logic rv, input logic [7:0] rd, input logic [2:0] bpf,
                      input logic rq, input logic we, input logic [11:0] a,
                      input logic [31:0] wd, input logic [31:0] exp, input string tag);
    @(posedge clk);
    #1;
    if (rq && !we) sb_q.push_back('{exp: exp, tag: tag});
    rx_valid = rv; rx_data = rd;
    {rx_brk, rx_par, rx_frm} = bpf;
    bus_req = rq; bus_we = we; bus_addr = a; bus_wdata = wd;
  endtask

  task automatic idle();
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 12'h0, 32'h0, 32'h0, "");
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] bpf);
    step(1'b1, d, bpf, 1'b0, 1'b0, 12'h0, 32'h0, 32'h0, "");
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0, a, 32'h0, exp, tag);
  endtask

  task automatic wr_clear(input logic [31:0] wd);
    step(1'b0, 8'h00, 3'b000, 1'b1, 1'b1, A_STAT, wd, 32'h0, "");
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(A_STAT, 32'h0, "R1 status after reset");
    rd(A_DATA, 32'h0, "R1 data after reset");

    // bpf = {brk, par, frm}
    push(8'hA5, 3'b001);
    push(8'h3C, 3'b010);
    push(8'h0F, 3'b100);
    rd(A_STAT, 32'h0, "R3 status before data read");
    rd(A_DATA, 32'h1A5, "R2 first char framing");
    rd(A_STAT, 32'h1, "R3 framing captured");
    rd(A_DATA, 32'h23C, "R2 second char parity");
    rd(A_STAT, 32'h2, "R3 parity captured");
    rd(A_DATA, 32'h40F, "R2 third char break");
    rd(A_STAT, 32'h4, "R3 break captured");
    rd(A_DATA, 32'h0, "R8 empty read data zero");
    rd(A_STAT, 32'h4, "R8 status unchanged");
    wr_clear(32'hFFFF_FFFF);
    rd(A_STAT, 32'h0, "R5 clear with ones");

    push(8'h11, 3'b000); push(8'h22, 3'b000);
    push(8'h33, 3'b000); push(8'h44, 3'b000);
    push(8'h55, 3'b111);
    rd(A_STAT, 32'h8, "R4 overrun set without read");
    rd(A_DATA, 32'h811, "R4 contents kept 11");
    rd(A_DATA, 32'h822, "R4 contents kept 22");
    rd(A_DATA, 32'h833, "R4 contents kept 33");
    rd(A_DATA, 32'h844, "R4 contents kept 44");
    rd(A_DATA, 32'h0, "R4 dropped char absent");
    rd(A_STAT, 32'h8, "R7 status upper zero");
    wr_clear(32'h0);
    rd(A_STAT, 32'h0, "R5 clear with zero");

    push(8'h66, 3'b000); push(8'h77, 3'b000);
    push(8'h88, 3'b000); push(8'h99, 3'b000);
    step(1'b1, 8'hAA, 3'b000, 1'b1, 1'b1, A_STAT, 32'h5A, 32'h0, "");
    rd(A_STAT, 32'h8, "R6 overrun beats clear");
    step(1'b1, 8'hBB, 3'b000, 1'b1, 1'b0, A_DATA, 32'h0, 32'h866, "R9 pop while push at full");
    rd(A_STAT, 32'h8, "R9 status after pop");
    wr_clear(32'h1);
    rd(A_STAT, 32'h0, "R9 no new overrun");
    rd(A_DATA, 32'h077, "R9 order 77");
    rd(A_DATA, 32'h088, "R9 order 88");
    rd(A_DATA, 32'h099, "R9 order 99");
    rd(A_DATA, 32'h0BB, "R9 accepted BB");

    push(8'hC3, 3'b111);
    rd(A_DATA, 32'h7C3, "R2 all flags");
    rd(A_STAT, 32'h7, "R3 all flags captured");
    wr_clear(32'h0000_0000);
    rd(A_STAT, 32'h0, "R5 clears all flags");
    idle();
    idle();

    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule